// File: doc/BRIEF.md
# Pulse-Driven Receive Decoder with Loss-of-Link Watchdog

This block sits on the receive side of a pulse-coupled isolation link. The transmitting side never sends a level. It sends a short "go high" pulse or a short "go low" pulse on every input edge. When the input is idle, it also repeats the pulse that matches the current level at a fixed refresh interval. The decoder keeps the received level in a set/reset storage element and presents it on `data_out`, so that the output tracks the far-side input level while both sides are alive.

A watchdog counts clock cycles since the last received pulse. A healthy link always refreshes before the limit, so an idle link never trips it. If the transmit side stops sending because it is unpowered or broken, the count reaches `WDOG_CYCLES` and the block enters a loss-of-link state. In that state `data_out` is forced high and `link_ok` drops. The next pulse of any kind ends the forced state and loads the new level in the same clock edge. A cycle in which both pulse inputs are asserted is treated as malformed: the stored level is kept and `protocol_error` is raised for one cycle.

All timing is in clock cycles. At 100 MHz the default limit of 500 cycles corresponds to about 5 µs. The inputs are expected to be already synchronous one-cycle pulses.

Top module: `pulse_decoder_wd`

## Requirements
- R1: While `rst` is high and right after it, `data_out` is 1, `link_ok` is 0 and `protocol_error` is 0; the link counts as lost until the first pulse.
- R2: A cycle with `set_pulse`=1 and `reset_pulse`=0 makes `data_out` 1 and `link_ok` 1 from the next clock edge.
- R3: A cycle with `reset_pulse`=1 and `set_pulse`=0 makes `data_out` 0 and `link_ok` 1 from the next clock edge.
- R4: With no pulse and the link alive, `data_out` keeps its last value.
- R5: After a pulse, `link_ok` stays 1 through WDOG_CYCLES-1 consecutive pulse-free cycles and goes 0 at the edge that ends the WDOG_CYCLES-th pulse-free cycle.
- R6: While `link_ok` is 0, `data_out` is 1 whatever level was last stored, and stays so for as long as no pulse arrives.
- R7: The first pulse after a loss of link clears the forced state and applies its own level at the same clock edge (a clear pulse yields `data_out`=0 immediately).
- R8: Every pulse restarts the watchdog, so pulses spaced at most WDOG_CYCLES-1 idle cycles apart keep `link_ok` at 1 indefinitely.
- R9: A cycle with both inputs at 1 leaves the stored level unchanged and raises `protocol_error` for exactly the following cycle.
- R10: A cycle with both inputs at 1 also counts as link activity and restarts the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 1 | One-cycle pulse requesting a high output level |
| reset_pulse | input | 1 | One-cycle pulse requesting a low output level |
| data_out | output | 1 | Decoded level, forced high while the link is lost |
| link_ok | output | 1 | High while the watchdog has not expired |
| protocol_error | output | 1 | One-cycle flag after a cycle with both pulses asserted |

## Verification
The bench targets the watchdog boundary. It checks `link_ok` after WDOG_CYCLES-1 idle cycles and again one cycle later. An off-by-one counter would drop the link one cycle early or late, and a healthy refresh stream at the maximum spacing would then fail. Recovery from the forced state uses a clear pulse. A design that cleared the forced state one cycle late, or ignored the level carried by the waking pulse, would show a stray high. Collisions are driven with both a stored 0 and a stored 1, which exposes any set or clear priority. The bench then counts the idle run after a collision, to catch a design that does not let a collision restart the watchdog.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    // Kind of event seen on the two pulse lines in one cycle
    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_SET  = 2'd1,
        EV_CLR  = 2'd2,
        EV_BOTH = 2'd3
    } pulse_ev_e;

    typedef struct packed {
        logic hi;   // request high level
        logic lo;   // request low level
    } pulse_pair_t;

    function automatic pulse_ev_e classify(input pulse_pair_t pp);
        unique case ({pp.hi, pp.lo})
            2'b10:   return EV_SET;
            2'b01:   return EV_CLR;
            2'b11:   return EV_BOTH;
            default: return EV_IDLE;
        endcase
    endfunction

    function automatic logic is_activity(input pulse_ev_e ev);
        return ev != EV_IDLE;
    endfunction

endpackage

// File: rtl/pdec_event_latch.sv
module pdec_event_latch
    import pdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pulse_pair_t pp,
    output logic        level_q,
    output logic        collide_q,
    output logic        activity
);

    pulse_ev_e ev;

    always_comb begin
        ev       = classify(pp);
        activity = is_activity(ev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= 1'b0;
            collide_q <= 1'b0;
        end else begin
            unique case (ev)
                EV_SET:  level_q <= 1'b1;
                EV_CLR:  level_q <= 1'b0;
                default: level_q <= level_q;
            endcase
            collide_q <= (ev == EV_BOTH);
        end
    end

endmodule

// File: rtl/pdec_watchdog.sv
module pdec_watchdog #(
    parameter int WDOG_CYCLES = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic activity,
    output logic expired
);

    localparam int CW = $clog2(WDOG_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            expired  <= 1'b1;
        end else if (activity) begin
            idle_cnt <= '0;
            expired  <= 1'b0;
        end else if (!expired) begin
            if (idle_cnt == LAST) begin
                expired <= 1'b1;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pulse_decoder_wd.sv
module pulse_decoder_wd
    import pdec_pkg::*;
#(
    parameter int WDOG_CYCLES = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic reset_pulse,
    output logic data_out,
    output logic link_ok,
    output logic protocol_error
);

    pulse_pair_t pp;
    logic        level_q;
    logic        collide_q;
    logic        activity;
    logic        expired;

    assign pp = '{hi: set_pulse, lo: reset_pulse};

    pdec_event_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .pp        (pp),
        .level_q   (level_q),
        .collide_q (collide_q),
        .activity  (activity)
    );

    pdec_watchdog #(
        .WDOG_CYCLES (WDOG_CYCLES)
    ) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .activity (activity),
        .expired  (expired)
    );

    // Safe level while the far side is silent
    assign data_out       = expired ? 1'b1 : level_q;
    assign link_ok        = ~expired;
    assign protocol_error = collide_q;

endmodule

// File: rtl/pdec_checker.sv
module pdec_checker (
    input logic clk,
    input logic rst,
    input logic set_pulse,
    input logic reset_pulse,
    input logic data_out,
    input logic link_ok,
    input logic protocol_error
);

    // R2
    set_drives_high_chk: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && !reset_pulse) |=> (data_out && link_ok));

    // R3
    clr_drives_low_chk: assert property (@(posedge clk) disable iff (rst)
        (reset_pulse && !set_pulse) |=> (!data_out && link_ok));

    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_pulse && !reset_pulse && link_ok) |=> (data_out == $past(data_out) || !link_ok));

    // R6
    lost_forces_high_chk: assert property (@(posedge clk) disable iff (rst)
        !link_ok |-> data_out);

    // R6
    lost_persists_chk: assert property (@(posedge clk) disable iff (rst)
        (!link_ok && !set_pulse && !reset_pulse) |=> !link_ok);

    // R5
    loss_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_ok) |-> $past(!set_pulse && !reset_pulse));

    // R9
    collide_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && reset_pulse) |=> protocol_error);

    // R9
    no_false_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !(set_pulse && reset_pulse) |=> !protocol_error);

    // R9
    collide_keeps_level_chk: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && reset_pulse && link_ok) |=> $stable(data_out));

    // R10
    collide_revives_chk: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && reset_pulse) |=> link_ok);

endmodule

bind pulse_decoder_wd pdec_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .set_pulse      (set_pulse),
    .reset_pulse    (reset_pulse),
    .data_out       (data_out),
    .link_ok        (link_ok),
    .protocol_error (protocol_error)
);

// File: tb/pulse_decoder_wd_tb.sv
`timescale 1ns/1ps
module pulse_decoder_wd_tb;

    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_pulse = 1'b0;
    logic reset_pulse = 1'b0;
    logic data_out, link_ok, protocol_error;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pulse_decoder_wd #(.WDOG_CYCLES(W)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .set_pulse      (set_pulse),
        .reset_pulse    (reset_pulse),
        .data_out       (data_out),
        .link_ok        (link_ok),
        .protocol_error (protocol_error)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle of pulse lines; return at the following negedge
    task automatic pulse(input logic s, input logic r);
        set_pulse   = s;
        reset_pulse = r;
        @(posedge clk);
        #1;
        set_pulse   = 1'b0;
        reset_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "data_out in reset", data_out, 1'b1);
        chk("R1", "link_ok in reset", link_ok, 1'b0);
        chk("R1", "protocol_error in reset", protocol_error, 1'b0);
        rst = 1'b0;
        idle(2);
        chk("R1", "data_out after reset", data_out, 1'b1);
        chk("R1", "link_ok after reset", link_ok, 1'b0);
    endtask

    task automatic t_set_clr();
        pulse(1'b1, 1'b0);
        chk("R2", "data_out after set", data_out, 1'b1);
        chk("R2", "link_ok after set", link_ok, 1'b1);
        pulse(1'b0, 1'b1);
        chk("R3", "data_out after clear", data_out, 1'b0);
        chk("R3", "link_ok after clear", link_ok, 1'b1);
    endtask

    task automatic t_hold_and_expire();
        for (int i = 0; i < W - 1; i++) begin
            idle(1);
            chk("R4", "data_out while idle", data_out, 1'b0);
            chk("R5", "link_ok before limit", link_ok, 1'b1);
        end
        idle(1);
        chk("R5", "link_ok at limit", link_ok, 1'b0);
        chk("R6", "data_out forced at limit", data_out, 1'b1);
        idle(10);
        chk("R6", "data_out stays forced", data_out, 1'b1);
        chk("R6", "link_ok stays low", link_ok, 1'b0);
    endtask

    task automatic t_recover();
        pulse(1'b0, 1'b1);
        chk("R7", "data_out on waking clear", data_out, 1'b0);
        chk("R7", "link_ok on waking clear", link_ok, 1'b1);
    endtask

    task automatic t_refresh();
        for (int k = 0; k < 8; k++) begin
            idle(W - 1);
            chk("R8", "link_ok at max spacing", link_ok, 1'b1);
            chk("R8", "data_out at max spacing", data_out, 1'b0);
            pulse(1'b0, 1'b1);
        end
        chk("R8", "link_ok after refresh run", link_ok, 1'b1);
    endtask

    task automatic t_collision();
        // stored 0: collision must not set
        pulse(1'b1, 1'b1);
        chk("R9", "data_out kept 0 on collision", data_out, 1'b0);
        chk("R9", "protocol_error after collision", protocol_error, 1'b1);
        idle(1);
        chk("R9", "protocol_error one cycle", protocol_error, 1'b0);
        // stored 1: collision must not clear
        pulse(1'b1, 1'b0);
        idle(3);
        pulse(1'b1, 1'b1);
        chk("R9", "data_out kept 1 on collision", data_out, 1'b1);
        chk("R9", "protocol_error second collision", protocol_error, 1'b1);
        idle(W - 1);
        chk("R10", "link_ok after collision restart", link_ok, 1'b1);
        idle(1);
        chk("R10", "link_ok lost after collision run", link_ok, 1'b0);
        // collision while lost revives link
        pulse(1'b1, 1'b1);
        chk("R10", "link_ok revived by collision", link_ok, 1'b1);
        chk("R9", "protocol_error while lost", protocol_error, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_set_clr();
        t_hold_and_expire();
        t_recover();
        t_refresh();
        t_collision();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule